// File: doc/BRIEF.md
# 12-bit Minifloat Add/Subtract/Multiply Unit

This block performs arithmetic on a compact 12-bit floating-point word: one sign bit in bit 11, a 4-bit exponent field in bits 10:7 stored with an offset of 7, and a 7-bit fraction in bits 6:0 sitting below an implied leading one. An exponent field of zero encodes zero, whatever the fraction bits hold. The word has no encodings for infinity, NaN or subnormals, so every nonzero exponent (1 to 15) is an ordinary number.

Two operands and a 2-bit operation code are presented each clock. The unit adds, subtracts or multiplies them. Subtraction uses the addition path with the second operand's sign inverted. One shared normalise-and-round stage finishes both paths. The result, a valid flag and overflow and underflow flags are registered, so they appear one clock after the inputs. Results round to nearest, with ties going to an even fraction. A result too large to represent saturates, and a result too small flushes to zero.

Top module: `mf_alu`

## Requirements
- R1: An operand whose exponent field (bits 10:7) is zero counts as zero in every operation, even when its fraction bits are nonzero.
- R2: Operation code 00 adds the operands. The smaller-exponent significand is aligned to the larger exponent, the exact sum is normalised, and it is rounded to nearest with ties to an even fraction.
- R3: Operation code 01 returns exactly the result of adding the first operand to the second operand with its sign bit inverted.
- R4: Operation code 10 multiplies the operands. The result is the rounded exact product, and its sign is the XOR of the operand signs.
- R5: When an addition or subtraction has a nonzero result, its sign is the sign of the operand with the larger magnitude. An exact zero result is always +0 (word 0x000), with neither flag set.
- R6: When the rounded biased exponent exceeds 15, the result is the largest finite magnitude with the computed sign (0x7FF or 0xFFF) and the overflow flag is 1.
- R7: When the rounded biased exponent is below 1 for a nonzero exact result, the result is zero carrying the computed sign (0x000 or 0x800) and the underflow flag is 1.
- R8: Operation code 11 gives valid 0, a zero result and both flags 0. Codes 00, 01 and 10 give valid 1.
- R9: Outputs are registered and reflect the inputs of the previous rising clock edge. While reset is low, the result, valid and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation code: 00 add, 01 subtract, 10 multiply, 11 none |
| a_i | input | 12 | First operand |
| b_i | input | 12 | Second operand |
| res_o | output | 12 | Rounded result word |
| valid_o | output | 1 | Result corresponds to a supported operation |
| ovf_o | output | 1 | Result saturated to the largest finite magnitude |
| unf_o | output | 1 | Result flushed to signed zero |

## Verification
Rounding and range limiting can act in the same cycle: a round-up that carries out of the fraction raises the exponent, and that alone can push the result past 15. The bench provokes this by adding the largest finite value to exactly half of its unit in the last place. That is a tie with an odd fraction, so the value rounds up into overflow, and the bench expects a saturated word with the overflow flag set. Cancellation and underflow also meet in one cycle: subtracting two adjacent smallest-exponent values leaves a tiny difference. The bench checks that this difference flushes to zero with the correct sign and the underflow flag set, and that exact cancellation instead yields +0 with no flag. Thousands of pseudo-random operand pairs are also compared against an exact integer model on every clock.

// File: rtl/mf_pkg.sv
package mf_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_MUL  = 2'b10,
        OP_NONE = 2'b11
    } mf_op_e;

endpackage

// File: rtl/mf_addsub.sv
// Aligns the smaller-magnitude significand and adds or subtracts.
// Output value = sig_o / 2^(IW-2) * 2^(exp_o - bias).
module mf_addsub #(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 7,
    parameter int IW     = 18,
    parameter int XW     = 8
) (
    input  logic [EXP_W+FRAC_W:0] a_i,
    input  logic [EXP_W+FRAC_W:0] b_i,
    input  logic                  sub_i,
    output logic                  sign_o,
    output logic signed [XW-1:0]  exp_o,
    output logic [IW-1:0]         sig_o
);
    localparam int W   = 1 + EXP_W + FRAC_W;
    localparam int MW  = FRAC_W + 1;
    localparam int PAD = IW - 1 - MW;

    logic              sb_eff;
    logic              a_big;
    logic              big_s, sml_s;
    logic [EXP_W-1:0]  big_e, sml_e, diff;
    logic [MW-1:0]     big_m, sml_m;
    logic [IW-1:0]     big_w, sml_w, sml_sh, sml_al;
    logic              lost;

    always_comb begin
        sb_eff = b_i[W-1] ^ sub_i;
        a_big  = (a_i[W-2:0] >= b_i[W-2:0]);
        big_s  = a_big ? a_i[W-1] : sb_eff;
        sml_s  = a_big ? sb_eff   : a_i[W-1];
        big_e  = a_big ? a_i[W-2:FRAC_W] : b_i[W-2:FRAC_W];
        sml_e  = a_big ? b_i[W-2:FRAC_W] : a_i[W-2:FRAC_W];
        big_m  = (big_e == '0) ? '0 :
                 {1'b1, (a_big ? a_i[FRAC_W-1:0] : b_i[FRAC_W-1:0])};
        sml_m  = (sml_e == '0) ? '0 :
                 {1'b1, (a_big ? b_i[FRAC_W-1:0] : a_i[FRAC_W-1:0])};
        diff   = big_e - sml_e;
        big_w  = {1'b0, big_m, {PAD{1'b0}}};
        sml_w  = {1'b0, sml_m, {PAD{1'b0}}};
        sml_sh = sml_w >> diff;
        lost   = |(sml_w & ~({IW{1'b1}} << diff));
        sml_al = sml_sh | {{(IW-1){1'b0}}, lost};
        sig_o  = (big_s == sml_s) ? (big_w + sml_al) : (big_w - sml_al);
        sign_o = big_s;
        exp_o  = XW'(big_e);
    end

    // R2: the larger operand never ends below the aligned smaller one
    always_comb begin
        a_r2_align_order: assert (big_w >= sml_al);
    end

endmodule

// File: rtl/mf_mul.sv
// Exact significand product; value = sig_o / 2^(IW-2) * 2^(exp_o - bias).
module mf_mul #(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 7,
    parameter int IW     = 18,
    parameter int XW     = 8
) (
    input  logic [EXP_W+FRAC_W:0] a_i,
    input  logic [EXP_W+FRAC_W:0] b_i,
    output logic                  sign_o,
    output logic signed [XW-1:0]  exp_o,
    output logic [IW-1:0]         sig_o
);
    localparam int W    = 1 + EXP_W + FRAC_W;
    localparam int MW   = FRAC_W + 1;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int LOW  = IW - 2 * MW;

    logic [EXP_W-1:0] ea, eb;
    logic [MW-1:0]    ma, mb;
    logic [2*MW-1:0]  prod;

    always_comb begin
        ea     = a_i[W-2:FRAC_W];
        eb     = b_i[W-2:FRAC_W];
        ma     = (ea == '0) ? '0 : {1'b1, a_i[FRAC_W-1:0]};
        mb     = (eb == '0) ? '0 : {1'b1, b_i[FRAC_W-1:0]};
        prod   = ma * mb;
        sig_o  = {prod, {LOW{1'b0}}};
        exp_o  = XW'(ea) + XW'(eb) - XW'(BIAS);
        sign_o = a_i[W-1] ^ b_i[W-1];
    end

    // R4: two nonzero significands give a product in [1, 4)
    always_comb begin
        if (ma != '0 && mb != '0)
            a_r4_prod_range: assert (prod[2*MW-1] || prod[2*MW-2]);
    end

endmodule

// File: rtl/mf_round.sv
// Normalises, rounds to nearest-even, saturates or flushes, and packs.
module mf_round #(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 7,
    parameter int IW     = 18,
    parameter int XW     = 8
) (
    input  logic                  sign_i,
    input  logic signed [XW-1:0]  exp_i,
    input  logic [IW-1:0]         sig_i,
    output logic [EXP_W+FRAC_W:0] res_o,
    output logic                  ovf_o,
    output logic                  unf_o
);
    localparam int MW  = FRAC_W + 1;
    localparam int LZW = $clog2(IW + 1);
    localparam logic signed [XW-1:0] E_MAX = XW'((1 << EXP_W) - 1);
    localparam logic signed [XW-1:0] E_MIN = XW'(1);

    logic [LZW-1:0]        lz;
    logic [IW-1:0]         norm;
    logic [MW-1:0]         mant, mant_r;
    logic                  guard, sticky;
    logic [MW:0]           rnd;
    logic signed [XW-1:0]  e_n, e_r;

    always_comb begin
        lz = '0;
        for (int i = 0; i < IW; i++) begin
            if (sig_i[i]) lz = LZW'(IW - 1 - i);
        end
        norm   = sig_i << lz;
        mant   = norm[IW-1 -: MW];
        guard  = norm[IW-1-MW];
        sticky = |norm[IW-2-MW:0];
        e_n    = exp_i + XW'(1) - XW'(lz);
        rnd    = {1'b0, mant} + (MW+1)'(guard & (sticky | mant[0]));
        if (rnd[MW]) begin
            mant_r = rnd[MW:1];
            e_r    = e_n + XW'(1);
        end else begin
            mant_r = rnd[MW-1:0];
            e_r    = e_n;
        end
        ovf_o = 1'b0;
        unf_o = 1'b0;
        if (sig_i == '0) begin
            res_o = '0;
        end else if (e_r > E_MAX) begin
            res_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
            ovf_o = 1'b1;
        end else if (e_r < E_MIN) begin
            res_o = {sign_i, {(EXP_W+FRAC_W){1'b0}}};
            unf_o = 1'b1;
        end else begin
            res_o = {sign_i, e_r[EXP_W-1:0], mant_r[FRAC_W-1:0]};
        end
    end

    // R2: the leading-one count must leave a set hidden bit after shifting
    always_comb begin
        if (sig_i != '0)
            a_r2_norm_lead: assert (mant[MW-1]);
    end

endmodule

// File: rtl/mf_alu.sv
module mf_alu #(
    parameter int EXP_W  = 4,
    parameter int FRAC_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               op_i,
    input  logic [EXP_W+FRAC_W:0]    a_i,
    input  logic [EXP_W+FRAC_W:0]    b_i,
    output logic [EXP_W+FRAC_W:0]    res_o,
    output logic                     valid_o,
    output logic                     ovf_o,
    output logic                     unf_o
);
    import mf_pkg::*;

    localparam int W  = 1 + EXP_W + FRAC_W;
    localparam int MW = FRAC_W + 1;
    localparam int IW = 2 * MW + 2;
    localparam int XW = EXP_W + 4;

    typedef struct packed {
        logic [W-1:0] res;
        logic         valid;
        logic         ovf;
        logic         unf;
    } out_t;

    out_t out_d, out_q;

    logic                 as_sign, mu_sign, r_sign;
    logic signed [XW-1:0] as_exp, mu_exp, r_exp;
    logic [IW-1:0]        as_sig, mu_sig, r_sig;
    logic [W-1:0]         r_res;
    logic                 r_ovf, r_unf;

    mf_addsub #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .IW(IW), .XW(XW)) u_addsub (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (op_i == OP_SUB),
        .sign_o (as_sign),
        .exp_o  (as_exp),
        .sig_o  (as_sig)
    );

    mf_mul #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .IW(IW), .XW(XW)) u_mul (
        .a_i    (a_i),
        .b_i    (b_i),
        .sign_o (mu_sign),
        .exp_o  (mu_exp),
        .sig_o  (mu_sig)
    );

    always_comb begin
        if (op_i == OP_MUL) begin
            r_sign = mu_sign;
            r_exp  = mu_exp;
            r_sig  = mu_sig;
        end else begin
            r_sign = as_sign;
            r_exp  = as_exp;
            r_sig  = as_sig;
        end
    end

    mf_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .IW(IW), .XW(XW)) u_round (
        .sign_i (r_sign),
        .exp_i  (r_exp),
        .sig_i  (r_sig),
        .res_o  (r_res),
        .ovf_o  (r_ovf),
        .unf_o  (r_unf)
    );

    always_comb begin
        out_d = '0;
        case (op_i)
            OP_ADD, OP_SUB, OP_MUL: begin
                out_d.res   = r_res;
                out_d.valid = 1'b1;
                out_d.ovf   = r_ovf;
                out_d.unf   = r_unf;
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o   = out_q.res;
    assign valid_o = out_q.valid;
    assign ovf_o   = out_q.ovf;
    assign unf_o   = out_q.unf;

    a_r8_none_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NONE) |=> (!valid_o && !ovf_o && !unf_o && res_o == '0));

    a_r6_sat_value: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (res_o[W-2:0] == {(W-1){1'b1}} && !unf_o));

    a_r7_flush_value: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> (res_o[W-2:0] == '0));

    a_r5_zero_positive: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && res_o[W-2:0] == '0 && !unf_o) |-> !res_o[W-1]);

    a_r4_mul_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_MUL && a_i[W-2:FRAC_W] != '0 && b_i[W-2:FRAC_W] != '0)
        |=> (res_o[W-1] == $past(a_i[W-1] ^ b_i[W-1])));

endmodule

// File: tb/mf_alu_tb.sv
module mf_alu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk;
    logic        rst_n;
    logic [1:0]  op;
    logic [11:0] a, b;
    logic [11:0] res;
    logic        valid, ovf, unf;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    mf_alu u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op),
        .a_i     (a),
        .b_i     (b),
        .res_o   (res),
        .valid_o (valid),
        .ovf_o   (ovf),
        .unf_o   (unf)
    );

    initial clk = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Exact model: value = m * 2^e, rounded to nearest-even then range-limited
    function automatic void pack_val(input bit s, input longint m, input int e,
                                     output logic [11:0] r, output logic o, output logic u);
        int p, ue, sh, be;
        longint q, rem, half;
        o = 0; u = 0;
        if (m == 0) begin r = 12'h000; return; end
        p = 0;
        for (int i = 0; i < 62; i++) if ((m >> i) & 1) p = i;
        ue = p + e;
        sh = p - 7;
        if (sh > 0) begin
            q    = m >> sh;
            rem  = m & ((longint'(1) << sh) - 1);
            half = longint'(1) << (sh - 1);
            if (rem > half || (rem == half && (q & 1))) q = q + 1;
        end else begin
            q = m << (-sh);
        end
        if (q == 256) begin q = 128; ue = ue + 1; end
        be = ue + 7;
        if (be > 15)     begin r = {s, 11'h7FF}; o = 1; end
        else if (be < 1) begin r = {s, 11'h000}; u = 1; end
        else r = {s, 4'(be), 7'(q)};
    endfunction

    function automatic void model(input logic [11:0] x, input logic [11:0] y, input logic [1:0] c,
                                  output logic [11:0] r, output logic v,
                                  output logic o, output logic u);
        bit sx, sy;
        int ex, ey;
        longint mx, my, sum;
        r = 0; v = 0; o = 0; u = 0;
        if (c == 2'b11) return;
        v  = 1;
        sx = x[11]; sy = y[11];
        ex = int'(x[10:7]); ey = int'(y[10:7]);
        mx = (ex == 0) ? 0 : 128 + longint'(x[6:0]);
        my = (ey == 0) ? 0 : 128 + longint'(y[6:0]);
        if (c == 2'b10) begin
            pack_val(sx ^ sy, mx * my, ex + ey - 28, r, o, u);
        end else begin
            if (c == 2'b01) sy = ~sy;
            sum = (sx ? -(mx << ex) : (mx << ex)) + (sy ? -(my << ey) : (my << ey));
            pack_val(sum < 0, (sum < 0) ? -sum : sum, -14, r, o, u);
        end
    endfunction

    task automatic check(input string tag, input logic [11:0] er, input logic ev,
                         input logic eo, input logic eu);
        checks++;
        if (res !== er || valid !== ev || ovf !== eo || unf !== eu) begin
            errors++;
            $display("FAIL %s: a=%h b=%h op=%0d got res=%h v=%b o=%b u=%b expected res=%h v=%b o=%b u=%b",
                     tag, a, b, op, res, valid, ovf, unf, er, ev, eo, eu);
        end
    endtask

    // Drive at a falling edge, result registered at the next rising edge,
    // compared at the falling edge after it.
    task automatic run(input logic [11:0] x, input logic [11:0] y, input logic [1:0] c,
                       input string tag);
        logic [11:0] er;
        logic ev, eo, eu;
        model(x, y, c, er, ev, eo, eu);
        a = x; b = y; op = c;
        @(negedge clk);
        check(tag, er, ev, eo, eu);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] st;
        string       tg;
        logic [11:0] er;
        logic ev, eo, eu;
        rst_n = 0; op = 2'b00; a = 12'h380; b = 12'h380;
        repeat (3) @(negedge clk);
        check("R9 reset", 12'h000, 1'b0, 1'b0, 1'b0);
        rst_n = 1;

        run(12'h380, 12'h380, 2'b00, "R2 1+1");
        if (res !== 12'h400) begin errors++; $display("FAIL R2 literal: got %h expected 400", res); end
        checks++;
        run(12'h580, 12'h180, 2'b00, "R2 tie even down");
        run(12'h581, 12'h180, 2'b00, "R2 tie odd up");
        run(12'h07F, 12'h380, 2'b00, "R1 zero exp with fraction");
        run(12'h380, 12'h87F, 2'b10, "R1 multiply by coded zero");
        run(12'h440, 12'h380, 2'b01, "R3 3-1");
        run(12'h380, 12'h380, 2'b01, "R5 x-x is +0");
        run(12'h380, 12'h440, 2'b01, "R5 1-3 negative");
        run(12'hB80, 12'hB80, 2'b00, "R5 -1 + -1");
        run(12'h800, 12'h800, 2'b00, "R5 -0 + -0 is +0");
        run(12'h3C0, 12'h3C0, 2'b10, "R4 1.5*1.5");
        run(12'hBC0, 12'h3C0, 2'b10, "R4 negative sign");
        run(12'h7FF, 12'h380, 2'b00, "R6 round carry into overflow");
        run(12'h7FF, 12'h7FF, 2'b10, "R6 mul overflow");
        run(12'hFFF, 12'h7FF, 2'b10, "R6 negative saturate");
        run(12'h081, 12'h080, 2'b01, "R7 cancellation underflow");
        run(12'h080, 12'h081, 2'b01, "R7 negative flush");
        run(12'h080, 12'h080, 2'b10, "R7 mul underflow");
        run(12'h880, 12'h080, 2'b10, "R7 signed flush");
        run(12'h380, 12'h380, 2'b11, "R8 no operation");
        run(12'h440, 12'h380, 2'b10, "R9 back-to-back latency");

        st = 32'h1234_5678;
        for (int k = 0; k < N_RANDOM; k++) begin
            logic [11:0] x, y;
            logic [1:0]  c;
            st ^= st << 13; st ^= st >> 17; st ^= st << 5;
            x = st[11:0]; y = st[23:12];
            c = (st[31:28] == 4'hF) ? 2'b11 : 2'(st[27:26] % 3);
            model(x, y, c, er, ev, eo, eu);
            if (c == 2'b11)      tg = "R8 random";
            else if (eo)         tg = "R6 random";
            else if (eu)         tg = "R7 random";
            else if (c == 2'b10) tg = "R4 random";
            else if (c == 2'b01) tg = "R3 random";
            else                 tg = "R2 random";
            run(x, y, c, tg);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule